// File: doc/BRIEF.md
# Frame Interrupt Entry and Halt Sequencer

This block sequences a small 8-bit processor's periodic frame interrupt. A free-running timer produces one frame strobe every `FRAME_CYCLES` clock cycles, which is one instruction slot per cycle. A strobe is accepted only while the interrupt-disable flag is clear. A strobe that arrives while the flag is set is dropped and is not held for later.

When a strobe is accepted, the sequencer stalls the core and performs the entry sequence through a byte-wide memory port and a stack-pointer step interface:

- It pushes the return PC and then the flags.
- It fetches the two-byte vector.
- It loads the vector into the PC.
- It loads a flags word in which only the disable flag is set.

On the return instruction it pops the flags and the PC in the reverse order. The popped disable bit decides whether interrupts are enabled again.

The block also owns the disable flag itself:

- The set instruction disables interrupts.
- The clear instruction enables them, except inside a handler, where it has no effect.
- A halt instruction stalls the core until a frame is taken. With interrupts disabled, a halt lasts until reset.

After reset, the block loads the reset PC and a flags word with only the disable flag set.

Top module: `frint_ctrl`

## Requirements
- R1: While reset is applied and in the first cycle after it, `pc_load` and `flags_load` are high with `pc_next` = 0x0000 and `flags_next` = 0x10. The disable flag is bit 4 of the flags. `irq_off` reads 1 after reset.
- R2: `frame_strobe` pulses for one cycle, once every `FRAME_CYCLES` cycles.
- R3: A frame is taken only when the strobe arrives while `irq_off` is 0. A strobe seen while `irq_off` is 1 is dropped, even if interrupts are enabled one cycle later. The `pc_load` of an entry comes 7 cycles after the strobe cycle of the accepted frame.
- R4: Entry writes three bytes with pre-decrement, one `sp_dec` per write. The PC high byte goes to SP-1, the PC low byte to SP-2, and the flags byte to SP-3. The flags byte is `flags_cur` with bit 4 replaced by the current disable flag.
- R5: Entry reads the vector low byte at 0xFF00 and the high byte at 0xFF01. It loads the vector into the PC with `pc_load`, loads `flags_next` = 0x10 with `flags_load`, and sets `irq_off` and `in_isr`.
- R6: A return instruction reads the flags at SP, the PC low byte at SP+1 and the PC high byte at SP+2, with one `sp_inc` per read. `pc_load` comes 4 cycles after the cycle in which `op_iret` is sampled. `irq_off` takes bit 4 of the popped flags, and `in_isr` clears.
- R7: `op_sif` sets `irq_off`. `op_cif` clears it only when `in_isr` is 0. Inside a handler, `op_cif` leaves `irq_off` at 1.
- R8: `op_halt` raises `halted` and `cpu_stall` until a frame is taken. While `irq_off` is 1, `halted` stays high until reset.
- R9: `cpu_stall` is high from the cycle in which a frame is taken through the entry's `pc_load` cycle, which is 7 cycles. For a return, it is high in the 4 cycles after `op_iret`. Instruction events are honoured only while `cpu_stall` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_halt | input | 1 | Halt instruction executed this cycle |
| op_sif | input | 1 | Disable-interrupts instruction executed this cycle |
| op_cif | input | 1 | Enable-interrupts instruction executed this cycle |
| op_iret | input | 1 | Interrupt-return instruction executed this cycle |
| pc_cur | input | AW | Address of the next instruction, saved on entry |
| flags_cur | input | DW | Current flags word, saved on entry |
| sp_cur | input | AW | Current stack pointer, which points at the last pushed byte |
| sp_dec | output | 1 | Decrement the stack pointer at this edge |
| sp_inc | output | 1 | Increment the stack pointer at this edge |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Access address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid one cycle after a read request |
| pc_load | output | 1 | Load `pc_next` into the PC |
| pc_next | output | AW | New PC value |
| flags_load | output | 1 | Load `flags_next` into the flags |
| flags_next | output | DW | New flags value |
| cpu_stall | output | 1 | Core must not retire instructions this cycle |
| halted | output | 1 | Core is in the halt wait |
| irq_off | output | 1 | Interrupt-disable flag |
| in_isr | output | 1 | Frame handler active |
| frame_strobe | output | 1 | One-cycle frame pulse |

## Verification
Each result is due a fixed number of edges after its stimulus:

- The entry `pc_load` comes 7 cycles after the strobe cycle.
- The return `pc_load` comes 4 cycles after the cycle in which `op_iret` is sampled.
- Flag instructions show on `irq_off` one edge later.
- Stack bytes land on the edges of the write cycles.

The bench timestamps strobes, return requests and PC loads on the rising edge, and compares the differences against these counts. It checks memory, stack pointer and flag state only at the falling edge after the load has been applied. Stall cycles are counted per edge and compared with 7 for an entry and 4 for a return.

// File: rtl/frint_pkg.sv
package frint_pkg;

   // Sequencer states: boot load, wait states, entry pushes and vector
   // fetch, then return pops.
   typedef enum logic [3:0] {
      ST_BOOT,
      ST_IDLE,
      ST_HALT,
      ST_PUSH_PCH,
      ST_PUSH_PCL,
      ST_PUSH_FLG,
      ST_VEC_LO,
      ST_VEC_HI,
      ST_VEC_JMP,
      ST_POP_FLG,
      ST_POP_PCL,
      ST_POP_PCH,
      ST_POP_JMP
   } seq_state_t;

endpackage

// File: rtl/frint_timer.sv
module frint_timer #(
   parameter int unsigned CYCLES = 66666
) (
   input  logic clk,
   input  logic rst_n,
   output logic strobe
);

   generate
      if (CYCLES == 1) begin : g_every
         // Degenerate period: a strobe on every cycle after reset.
         logic on_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) on_q <= 1'b0;
            else        on_q <= 1'b1;
         end
         assign strobe = on_q;
      end else begin : g_count
         localparam int unsigned CW = $clog2(CYCLES);
         localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             cnt_q <= '0;
            else if (cnt_q == LAST) cnt_q <= '0;
            else                    cnt_q <= cnt_q + CW'(1);
         end
         assign strobe = (cnt_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/frint_mask.sv
module frint_mask (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic take,
   input  logic set_req,
   input  logic clr_req,
   input  logic restore_en,
   input  logic restore_val,
   output logic if_q,
   output logic isr_q,
   output logic pend_q
);

   logic if_d;
   logic isr_d;
   logic pend_d;

   // Priority: entry, then restore on return, then set, then clear.
   always_comb begin
      if_d = if_q;
      if (take)                  if_d = 1'b1;
      else if (restore_en)       if_d = restore_val;
      else if (set_req)          if_d = 1'b1;
      else if (clr_req && !isr_q) if_d = 1'b0;
   end

   always_comb begin
      isr_d = isr_q;
      if (take)            isr_d = 1'b1;
      else if (restore_en) isr_d = 1'b0;
   end

   // A strobe is remembered only while the flag is clear now and next cycle.
   always_comb begin
      pend_d = !if_q && !if_d && (tick || (pend_q && !take));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         if_q   <= 1'b1;
         isr_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         if_q   <= if_d;
         isr_q  <= isr_d;
         pend_q <= pend_d;
      end
   end

endmodule

// File: rtl/frint_fsm.sv
module frint_fsm
   import frint_pkg::*;
#(
   parameter int unsigned DW       = 8,
   parameter int unsigned AW       = 16,
   parameter int unsigned IF_BIT   = 4,
   parameter int unsigned VEC_ADDR = 'hFF00,
   parameter int unsigned RESET_PC = 'h0000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pend,
   input  logic          if_q,
   input  logic          op_halt,
   input  logic          op_iret,
   input  logic [AW-1:0] pc_cur,
   input  logic [DW-1:0] flags_cur,
   input  logic [AW-1:0] sp_cur,
   input  logic [DW-1:0] mem_rdata,
   output logic          take,
   output logic          op_ok,
   output logic          restore_en,
   output logic          restore_val,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic          sp_dec,
   output logic          sp_inc,
   output logic          pc_load,
   output logic [AW-1:0] pc_next,
   output logic          flags_load,
   output logic [DW-1:0] flags_next,
   output logic          stall,
   output logic          halted
);

   localparam logic [AW-1:0] VEC_LO_A = AW'(VEC_ADDR);
   localparam logic [AW-1:0] VEC_HI_A = AW'(VEC_ADDR + 1);
   localparam logic [AW-1:0] BOOT_PC  = AW'(RESET_PC);
   localparam logic [DW-1:0] IF_MASK  = {{(DW-1){1'b0}}, 1'b1} << IF_BIT;

   seq_state_t    st_q, st_d;
   logic [AW-1:0] pc_sv_q;
   logic [DW-1:0] flg_sv_q;
   logic [DW-1:0] byte_q;
   logic [AW-1:0] push_addr;

   // Pre-decrement stack: a push lands one below the current pointer.
   assign push_addr = sp_cur - AW'(1);

   assign take   = pend && !if_q && ((st_q == ST_IDLE) || (st_q == ST_HALT));
   assign op_ok  = (st_q == ST_IDLE) && !take;
   assign stall  = (st_q != ST_IDLE) || take;
   assign halted = (st_q == ST_HALT);

   always_comb begin
      st_d        = st_q;
      mem_req     = 1'b0;
      mem_we      = 1'b0;
      mem_addr    = '0;
      mem_wdata   = '0;
      sp_dec      = 1'b0;
      sp_inc      = 1'b0;
      pc_load     = 1'b0;
      pc_next     = '0;
      flags_load  = 1'b0;
      flags_next  = '0;
      restore_en  = 1'b0;
      restore_val = 1'b0;
      case (st_q)
         ST_BOOT: begin
            pc_load    = 1'b1;
            pc_next    = BOOT_PC;
            flags_load = 1'b1;
            flags_next = IF_MASK;
            st_d       = ST_IDLE;
         end
         ST_IDLE: begin
            if (take)         st_d = ST_PUSH_PCH;
            else if (op_iret) st_d = ST_POP_FLG;
            else if (op_halt) st_d = ST_HALT;
         end
         ST_HALT: begin
            if (take) st_d = ST_PUSH_PCH;
         end
         ST_PUSH_PCH: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = push_addr;
            mem_wdata = pc_sv_q[AW-1:DW];
            sp_dec    = 1'b1;
            st_d      = ST_PUSH_PCL;
         end
         ST_PUSH_PCL: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = push_addr;
            mem_wdata = pc_sv_q[DW-1:0];
            sp_dec    = 1'b1;
            st_d      = ST_PUSH_FLG;
         end
         ST_PUSH_FLG: begin
            mem_req    = 1'b1;
            mem_we     = 1'b1;
            mem_addr   = push_addr;
            mem_wdata  = flg_sv_q;
            sp_dec     = 1'b1;
            flags_load = 1'b1;
            flags_next = IF_MASK;
            st_d       = ST_VEC_LO;
         end
         ST_VEC_LO: begin
            mem_req  = 1'b1;
            mem_addr = VEC_LO_A;
            st_d     = ST_VEC_HI;
         end
         ST_VEC_HI: begin
            mem_req  = 1'b1;
            mem_addr = VEC_HI_A;
            st_d     = ST_VEC_JMP;
         end
         ST_VEC_JMP: begin
            pc_load = 1'b1;
            pc_next = {mem_rdata, byte_q};
            st_d    = ST_IDLE;
         end
         ST_POP_FLG: begin
            mem_req  = 1'b1;
            mem_addr = sp_cur;
            sp_inc   = 1'b1;
            st_d     = ST_POP_PCL;
         end
         ST_POP_PCL: begin
            mem_req     = 1'b1;
            mem_addr    = sp_cur;
            sp_inc      = 1'b1;
            flags_load  = 1'b1;
            flags_next  = mem_rdata;
            restore_en  = 1'b1;
            restore_val = mem_rdata[IF_BIT];
            st_d        = ST_POP_PCH;
         end
         ST_POP_PCH: begin
            mem_req  = 1'b1;
            mem_addr = sp_cur;
            sp_inc   = 1'b1;
            st_d     = ST_POP_JMP;
         end
         ST_POP_JMP: begin
            pc_load = 1'b1;
            pc_next = {mem_rdata, byte_q};
            st_d    = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_BOOT;
         pc_sv_q  <= '0;
         flg_sv_q <= '0;
         byte_q   <= '0;
      end else begin
         st_q <= st_d;
         if (take) begin
            pc_sv_q  <= pc_cur;
            flg_sv_q <= (flags_cur & ~IF_MASK) | (if_q ? IF_MASK : '0);
         end
         // Low byte of a two-byte read arrives while the high byte is requested.
         if ((st_q == ST_VEC_HI) || (st_q == ST_POP_PCH)) byte_q <= mem_rdata;
      end
   end

endmodule

// File: rtl/frint_ctrl.sv
module frint_ctrl #(
   parameter int unsigned DW           = 8,
   parameter int unsigned AW           = 16,
   parameter int unsigned IF_BIT       = 4,
   parameter int unsigned VEC_ADDR     = 'hFF00,
   parameter int unsigned RESET_PC     = 'h0000,
   parameter int unsigned FRAME_CYCLES = 66666
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          op_halt,
   input  logic          op_sif,
   input  logic          op_cif,
   input  logic          op_iret,
   input  logic [AW-1:0] pc_cur,
   input  logic [DW-1:0] flags_cur,
   input  logic [AW-1:0] sp_cur,
   output logic          sp_dec,
   output logic          sp_inc,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic          pc_load,
   output logic [AW-1:0] pc_next,
   output logic          flags_load,
   output logic [DW-1:0] flags_next,
   output logic          cpu_stall,
   output logic          halted,
   output logic          irq_off,
   output logic          in_isr,
   output logic          frame_strobe
);

   // Elaboration-time parameter checks.
   generate
      if (DW < 2) begin : g_bad_dw
         $error("frint_ctrl: DW must be at least 2");
      end
      if (AW != 2 * DW) begin : g_bad_aw
         $error("frint_ctrl: AW must be twice DW");
      end
      if (IF_BIT >= DW) begin : g_bad_bit
         $error("frint_ctrl: IF_BIT outside the flags word");
      end
      if (FRAME_CYCLES < 1) begin : g_bad_frame
         $error("frint_ctrl: FRAME_CYCLES must be positive");
      end
      if (VEC_ADDR + 1 >= (64'd1 << AW)) begin : g_bad_vec
         $error("frint_ctrl: vector does not fit the address space");
      end
   endgenerate

   logic tick;
   logic take;
   logic op_ok;
   logic pend;
   logic if_q;
   logic isr_q;
   logic restore_en;
   logic restore_val;

   frint_timer #(.CYCLES(FRAME_CYCLES)) i_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (tick)
   );

   frint_mask i_mask (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .take        (take),
      .set_req     (op_sif && op_ok),
      .clr_req     (op_cif && op_ok),
      .restore_en  (restore_en),
      .restore_val (restore_val),
      .if_q        (if_q),
      .isr_q       (isr_q),
      .pend_q      (pend)
   );

   frint_fsm #(
      .DW       (DW),
      .AW       (AW),
      .IF_BIT   (IF_BIT),
      .VEC_ADDR (VEC_ADDR),
      .RESET_PC (RESET_PC)
   ) i_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .pend        (pend),
      .if_q        (if_q),
      .op_halt     (op_halt),
      .op_iret     (op_iret),
      .pc_cur      (pc_cur),
      .flags_cur   (flags_cur),
      .sp_cur      (sp_cur),
      .mem_rdata   (mem_rdata),
      .take        (take),
      .op_ok       (op_ok),
      .restore_en  (restore_en),
      .restore_val (restore_val),
      .mem_req     (mem_req),
      .mem_we      (mem_we),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata),
      .sp_dec      (sp_dec),
      .sp_inc      (sp_inc),
      .pc_load     (pc_load),
      .pc_next     (pc_next),
      .flags_load  (flags_load),
      .flags_next  (flags_next),
      .stall       (cpu_stall),
      .halted      (halted)
   );

   assign irq_off      = if_q;
   assign in_isr       = isr_q;
   assign frame_strobe = tick;

endmodule

// File: rtl/frint_ctrl_chk.sv
module frint_ctrl_chk #(
   parameter int unsigned FRAME_CYCLES = 66666
) (
   input logic clk,
   input logic rst_n,
   input logic frame_strobe,
   input logic irq_off,
   input logic in_isr,
   input logic halted,
   input logic cpu_stall,
   input logic pc_load,
   input logic mem_req,
   input logic mem_we,
   input logic sp_dec,
   input logic sp_inc
);

   generate
      if (FRAME_CYCLES > 1) begin : g_spaced
         AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            frame_strobe |=> !frame_strobe); // R2
      end
   endgenerate

   AST_TAKE_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_isr) |-> !$past(irq_off)); // R3

   AST_SP_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
      !(sp_dec && sp_inc)); // R4

   AST_WRITE_DECS: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> sp_dec); // R4

   AST_POP_READS: assert property (@(posedge clk) disable iff (!rst_n)
      sp_inc |-> (mem_req && !mem_we)); // R6

   AST_ISR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      in_isr |-> irq_off); // R7

   AST_HALT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> cpu_stall); // R8

   AST_HALT_FOREVER: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && irq_off) |=> halted); // R8

   AST_LOAD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |-> cpu_stall); // R9

endmodule

bind frint_ctrl frint_ctrl_chk #(.FRAME_CYCLES(FRAME_CYCLES)) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .frame_strobe (frame_strobe),
   .irq_off      (irq_off),
   .in_isr       (in_isr),
   .halted       (halted),
   .cpu_stall    (cpu_stall),
   .pc_load      (pc_load),
   .mem_req      (mem_req),
   .mem_we       (mem_we),
   .sp_dec       (sp_dec),
   .sp_inc       (sp_inc)
);

// File: tb/test_frint_ctrl.sv
module test_frint_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int FRAMES     = 50;
   localparam int LIMIT      = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_halt = 1'b0, op_sif = 1'b0, op_cif = 1'b0, op_iret = 1'b0;
   logic [15:0] pc_drive = 16'h0BAD;
   logic [7:0]  flag_drive = 8'h00;
   logic [15:0] sp_reg = 16'hFFF0;
   logic [15:0] pc_reg = 16'h0000;
   logic [7:0]  f_reg = 8'h00;
   logic [7:0]  rdata = 8'h00;
   logic [7:0]  mem [0:255];

   logic        sp_dec, sp_inc, mem_req, mem_we, pc_load, flags_load;
   logic        cpu_stall, halted, irq_off, in_isr, frame_strobe;
   logic [15:0] mem_addr, pc_next;
   logic [7:0]  mem_wdata, flags_next;

   int cyc = 0, nload = 0, nwr = 0, nstrobe = 0, stall_cnt = 0;
   int strobe_cyc = 0, prev_strobe = 0, load_cyc = 0, iret_cyc = 0;
   int n_chk = 0, n_bad = 0;

   frint_ctrl #(.FRAME_CYCLES(FRAMES)) i_frint_ctrl (
      .clk (clk), .rst_n (rst_n),
      .op_halt (op_halt), .op_sif (op_sif), .op_cif (op_cif), .op_iret (op_iret),
      .pc_cur (pc_drive), .flags_cur (flag_drive), .sp_cur (sp_reg),
      .sp_dec (sp_dec), .sp_inc (sp_inc),
      .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr),
      .mem_wdata (mem_wdata), .mem_rdata (rdata),
      .pc_load (pc_load), .pc_next (pc_next),
      .flags_load (flags_load), .flags_next (flags_next),
      .cpu_stall (cpu_stall), .halted (halted), .irq_off (irq_off),
      .in_isr (in_isr), .frame_strobe (frame_strobe)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   // Core model: PC, flags, stack pointer and a one-page memory (page 0xFF).
   always @(posedge clk) begin
      if (!rst_n) sp_reg <= 16'hFFF0;
      else if (sp_dec) sp_reg <= sp_reg - 16'd1;
      else if (sp_inc) sp_reg <= sp_reg + 16'd1;
      if (pc_load) begin
         pc_reg <= pc_next;
         nload++;
         load_cyc = cyc;
      end
      if (flags_load) f_reg <= flags_next;
      if (mem_req && mem_we) begin
         mem[mem_addr[7:0]] <= mem_wdata;
         nwr++;
      end
      if (mem_req && !mem_we) rdata <= mem[mem_addr[7:0]];
      if (cpu_stall && rst_n) stall_cnt++;
      if (op_iret && !cpu_stall) iret_cyc = cyc;
      if (frame_strobe && rst_n) begin
         if (nstrobe > 0) chk("R2 strobe period", cyc - prev_strobe, FRAMES);
         prev_strobe = cyc;
         strobe_cyc  = cyc;
         nstrobe++;
      end
      cyc++;
      if (cyc == LIMIT) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         report();
      end
   end

   task automatic pulse(input int which);
      case (which)
         0: op_halt = 1'b1;
         1: op_sif  = 1'b1;
         2: op_cif  = 1'b1;
         default: op_iret = 1'b1;
      endcase
      @(negedge clk);
      op_halt = 1'b0; op_sif = 1'b0; op_cif = 1'b0; op_iret = 1'b0;
   endtask

   task automatic wait_load(input string tag);
      int n0;
      n0 = nload;
      for (int i = 0; i < 400 && nload == n0; i++) @(negedge clk);
      if (nload == n0) chk(tag, 0, 1);
   endtask

   task automatic do_reset(input bit check_r1);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      if (check_r1) begin
         chk("R1 pc_load in reset", pc_load, 1);
         chk("R1 pc_next in reset", pc_next, 16'h0000);
         chk("R1 flags_next in reset", {flags_load, flags_next}, 9'h110);
         chk("R1 irq_off in reset", irq_off, 1);
      end
      nstrobe = 0;
      rst_n = 1'b1;
      @(negedge clk);
      if (check_r1) begin
         chk("R1 pc after boot", pc_reg, 16'h0000);
         chk("R1 flags after boot", f_reg, 8'h10);
         chk("R1 stall released", cpu_stall, 0);
      end
   endtask

   initial begin
      logic [15:0] vec;
      logic [7:0]  expf;
      int s0, w0, n0;
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      do_reset(1'b1);

      // Strobes while disabled: no entry, strobe spacing checked by monitor.
      for (int i = 0; i < 400 && nstrobe < 3; i++) @(negedge clk);
      chk("R3 no entry while disabled", nwr, 0);
      chk("R3 irq_off still set", irq_off, 1);

      // Halt with interrupts disabled never ends.
      pulse(0);
      chk("R8 halted raised", halted, 1);
      repeat (2 * FRAMES) @(negedge clk);
      chk("R8 halt persists", {halted, cpu_stall}, 2'b11);
      chk("R8 no entry from halt", nwr, 0);
      do_reset(1'b0);

      for (int k = 0; k < 4; k++) begin
         vec = 16'h0300 + 16'(k) * 16'h1107;
         mem[0] = vec[7:0];
         mem[1] = vec[15:8];
         pc_drive   = 16'h1234 + 16'(k) * 16'h2111;
         flag_drive = 8'hE0 | 8'(k);
         if (k == 0) begin
            pulse(2);
            chk("R7 cif outside handler", irq_off, 0);
         end
         if (k == 1) begin
            pulse(0);
            chk("R8 halt waits", {halted, cpu_stall}, 2'b11);
         end
         s0 = stall_cnt;
         w0 = nwr;
         wait_load("R5 entry load");
         chk("R5 vector in pc", pc_reg, vec);
         chk("R3 entry latency", load_cyc - strobe_cyc, 7);
         chk("R5 flags cleared", f_reg, 8'h10);
         chk("R5 irq_off/in_isr", {irq_off, in_isr}, 2'b11);
         chk("R4 sp after entry", sp_reg, 16'hFFED);
         chk("R4 pc high at sp-1", mem[8'hEF], pc_drive[15:8]);
         chk("R4 pc low at sp-2", mem[8'hEE], pc_drive[7:0]);
         chk("R4 flags at sp-3", mem[8'hED], flag_drive);
         chk("R4 write count", nwr - w0, 3);
         if (k == 1) chk("R8 halt left", halted, 0);
         else        chk("R9 entry stall cycles", stall_cnt - s0, 7);

         pulse(2);
         chk("R7 cif inside handler", irq_off, 1);
         if (k == 3) mem[8'hED] = mem[8'hED] | 8'h10;
         expf = mem[8'hED];
         s0 = stall_cnt;
         pulse(3);
         wait_load("R6 return load");
         chk("R6 pc restored", pc_reg, pc_drive);
         chk("R6 return latency", load_cyc - iret_cyc, 4);
         chk("R6 flags restored", f_reg, expf);
         chk("R6 sp restored", sp_reg, 16'hFFF0);
         chk("R6 in_isr cleared", in_isr, 0);
         chk("R6 irq_off from popped bit 4", irq_off, (k == 3) ? 1 : 0);
         chk("R9 return stall cycles", stall_cnt - s0, 4);
      end

      // Restored disable flag keeps frames out.
      w0 = nwr;
      repeat (2 * FRAMES) @(negedge clk);
      chk("R3 masked after restore", nwr, w0);

      // A strobe seen while disabled is dropped even if enabled right after.
      n0 = nstrobe;
      for (int i = 0; i < 400 && nstrobe == n0; i++) @(negedge clk);
      pulse(2);
      chk("R7 cif re-enables", irq_off, 0);
      w0 = nwr;
      repeat (FRAMES - 10) @(negedge clk);
      chk("R3 dropped strobe not held", nwr, w0);
      wait_load("R3 next frame taken");
      chk("R3 next frame latency", load_cyc - strobe_cyc, 7);
      pulse(1);
      chk("R7 sif inside handler", irq_off, 1);
      pulse(3);
      wait_load("R6 final return");
      chk("R6 enabled after return", irq_off, 0);
      pulse(1);
      chk("R7 sif outside handler", irq_off, 1);
      report();
   end

endmodule